// File: doc/BRIEF.md
# Serial Controller Interrupt Identifier

This block collects the interrupt conditions of a 16450/16550-style asynchronous serial controller. It keeps the sticky ones in flags, applies a per-source enable, and presents only the most urgent pending condition as a 3-bit identification code beside an active-low pending flag. The same pending state, gated by a global output enable, drives the interrupt request line toward the host.

Host register accesses arrive as single-cycle strobes. Each strobe clears the sources that access retires. Reading the line status register retires the error condition. Reading the receive buffer retires a received character. Reading the modem status register retires a modem change. Writing the transmit holding register, or reading the identification register while the transmit-empty condition is the one being reported, retires transmit-empty. In FIFO mode the receive condition follows the FIFO trigger level directly, and a character timeout level becomes a second source at the same urgency as received data.

Top module: `uart_irq_ident`

## Requirements
- R1: Right after reset no interrupt is pending: `int_pend_n_o`=1, `irq_o`=0. Whenever `int_pend_n_o`=1, `iid_o` reads 000.
- R2: A pulse on `line_err_i` latches a line error. With enable bit 2 set, it is reported as code 011 ahead of every other source from the next cycle. A `rd_lsr_i` strobe with no simultaneous error clears it.
- R3: In character mode (`fifo_mode_i`=0), a pulse on `rx_evt_i` latches a received character. With enable bit 0 set, it is reported as code 010. `rd_rbr_i` clears it, and other read strobes leave it standing.
- R4: In FIFO mode the receive condition is the `rx_trig_i` level itself. It is reported as code 010 while high and disappears when it falls.
- R5: In FIFO mode a high `rx_tmo_i` with enable bit 0 set is reported as code 110. When received data is also pending, 010 is reported instead.
- R6: A rising edge of `thr_empty_i` arms transmit-empty. With enable bit 1 set, it is reported as code 001 below line error and receive, and above modem. `wr_thr_i` clears it. A `rd_iir_i` strobe in a cycle where 001 is the reported code also clears it.
- R7: A `rd_iir_i` strobe in a cycle where some other code is reported leaves transmit-empty armed.
- R8: Changing enable bit 1 from 0 to 1 while `thr_empty_i` is high arms transmit-empty, even with no new edge on `thr_empty_i`.
- R9: A pulse on `msr_evt_i` latches a modem change. With enable bit 3 set, it is reported as code 000 with `int_pend_n_o`=0, at the lowest urgency. `rd_msr_i` clears it.
- R10: A source whose enable bit is 0 is never reported and never raises `irq_o`. The bit positions are: 0 receive/timeout, 1 transmit-empty, 2 line error, 3 modem.
- R11: `irq_o` is 1 exactly when `out_en_i`=1 and `int_pend_n_o`=0.
- R12: In character mode `iid_o[2]` is always 0. A high `rx_tmo_i` is ignored in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode_i | input | 1 | 1 selects FIFO mode, 0 character mode |
| src_en_i | input | 4 | Per-source enables (0 receive, 1 transmit-empty, 2 line error, 3 modem) |
| out_en_i | input | 1 | Global gate on the request line |
| line_err_i | input | 1 | Pulse: overrun, parity, framing or break seen |
| rx_evt_i | input | 1 | Pulse: character placed in the receive buffer (character mode) |
| rx_trig_i | input | 1 | Level: receive FIFO at or above its trigger level |
| rx_tmo_i | input | 1 | Level: receive character timeout condition |
| thr_empty_i | input | 1 | Level: transmit holding register empty |
| msr_evt_i | input | 1 | Pulse: modem input changed state |
| rd_iir_i | input | 1 | Strobe: identification register read |
| rd_lsr_i | input | 1 | Strobe: line status register read |
| rd_rbr_i | input | 1 | Strobe: receive buffer read |
| rd_msr_i | input | 1 | Strobe: modem status register read |
| wr_thr_i | input | 1 | Strobe: transmit holding register write |
| iid_o | output | 3 | Code of the most urgent pending source |
| int_pend_n_o | output | 1 | 0 when some enabled source is pending |
| irq_o | output | 1 | Interrupt request line |

## Verification
The hardest state to reach is transmit-empty armed while another source hides it. In that state an identification read must not clear it, and the same read must clear it once it becomes the reported code. To reach this, the bench sweeps every mix of the five sources against every enable pattern in both modes, arming transmit-empty through a real low-to-high edge after a quiet cycle. In every mix it issues an identification read and recomputes which sources should survive. Directed sequences then arm transmit-empty through an enable change alone, and check each clearing strobe against both its own source and the sources it must leave alone.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   typedef enum logic [2:0] {
      IID_MDM  = 3'b000,
      IID_THRE = 3'b001,
      IID_RXD  = 3'b010,
      IID_LINE = 3'b011,
      IID_TMO  = 3'b110
   } iid_e;

   localparam int EN_W    = 4;
   localparam int EN_RXD  = 0;
   localparam int EN_THRE = 1;
   localparam int EN_LINE = 2;
   localparam int EN_MDM  = 3;

   typedef struct packed {
      logic line;
      logic rxd;
      logic tmo;
      logic thre;
      logic mdm;
   } src_t;

endpackage

// File: rtl/uirq_flag.sv
// Sticky source flag: set by an event pulse, cleared by a register access.
module uirq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (set_i)      flag_d = 1'b1;
            else if (clr_i) flag_d = 1'b0;
            else            flag_d = flag_o;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr_i)      flag_d = 1'b0;
            else if (set_i) flag_d = 1'b1;
            else            flag_d = flag_o;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= flag_d;
   end
endmodule

// File: rtl/uirq_thre_arm.sv
// Transmit-empty arming: edge of the empty level, optionally also the enable edge.
module uirq_thre_arm #(
   parameter bit ARM_ON_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic empty_i,
   input  logic en_i,
   input  logic clr_i,
   output logic flag_o
);
   logic empty_q;
   logic en_q;
   logic edge_arm;
   logic en_arm;

   assign edge_arm = empty_i & ~empty_q;

   generate
      if (ARM_ON_EN) begin : g_en_arm
         assign en_arm = en_i & ~en_q & empty_i;
      end else begin : g_no_en_arm
         assign en_arm = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         en_q    <= 1'b0;
         flag_o  <= 1'b0;
      end else begin
         empty_q <= empty_i;
         en_q    <= en_i;
         if (edge_arm || en_arm) flag_o <= 1'b1;
         else if (clr_i)         flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/uirq_prio.sv
// Fixed-priority encoder from enabled pending sources to identification code.
module uirq_prio
   import uirq_pkg::*;
(
   input  src_t       pend_i,
   output logic [2:0] iid_o,
   output logic       pend_n_o
);
   iid_e code;

   always_comb begin
      pend_n_o = 1'b0;
      code     = IID_MDM;
      if (pend_i.line)      code = IID_LINE;
      else if (pend_i.rxd)  code = IID_RXD;
      else if (pend_i.tmo)  code = IID_TMO;
      else if (pend_i.thre) code = IID_THRE;
      else if (pend_i.mdm)  code = IID_MDM;
      else                  pend_n_o = 1'b1;
   end

   assign iid_o = code;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uirq_pkg::*;
#(
   parameter bit          HAS_FIFO       = 1'b1,
   parameter bit          THRE_ARM_ON_EN = 1'b1,
   parameter bit          EVT_SET_WINS   = 1'b1,
   parameter int unsigned IID_W          = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fifo_mode_i,
   input  logic [EN_W-1:0] src_en_i,
   input  logic            out_en_i,
   input  logic            line_err_i,
   input  logic            rx_evt_i,
   input  logic            rx_trig_i,
   input  logic            rx_tmo_i,
   input  logic            thr_empty_i,
   input  logic            msr_evt_i,
   input  logic            rd_iir_i,
   input  logic            rd_lsr_i,
   input  logic            rd_rbr_i,
   input  logic            rd_msr_i,
   input  logic            wr_thr_i,
   output logic [IID_W-1:0] iid_o,
   output logic            int_pend_n_o,
   output logic            irq_o
);
   generate
      if (IID_W != $bits(iid_e)) begin : g_bad_iid_w
         $error("IID_W must match the identification code width");
      end
   endgenerate

   logic fifo_eff;
   logic line_q, rxc_q, thre_q, mdm_q;
   logic thre_clr;
   logic rx_src, tmo_src;
   logic [2:0] code;
   src_t pend;

   generate
      if (HAS_FIFO) begin : g_fifo
         assign fifo_eff = fifo_mode_i;
         assign rx_src   = fifo_mode_i ? rx_trig_i : rxc_q;
         assign tmo_src  = fifo_mode_i & rx_tmo_i;
      end else begin : g_char_only
         assign fifo_eff = 1'b0;
         assign rx_src   = rxc_q;
         assign tmo_src  = 1'b0;
      end
   endgenerate

   uirq_flag #(.SET_WINS(EVT_SET_WINS)) u_line (
      .clk(clk), .rst_n(rst_n), .set_i(line_err_i), .clr_i(rd_lsr_i), .flag_o(line_q));

   uirq_flag #(.SET_WINS(EVT_SET_WINS)) u_rxc (
      .clk(clk), .rst_n(rst_n), .set_i(rx_evt_i & ~fifo_eff),
      .clr_i(rd_rbr_i | fifo_eff), .flag_o(rxc_q));

   uirq_flag #(.SET_WINS(EVT_SET_WINS)) u_mdm (
      .clk(clk), .rst_n(rst_n), .set_i(msr_evt_i), .clr_i(rd_msr_i), .flag_o(mdm_q));

   // Identification read retires transmit-empty only when it is the code shown.
   assign thre_clr = wr_thr_i | (rd_iir_i & ~int_pend_n_o & (code == IID_THRE));

   uirq_thre_arm #(.ARM_ON_EN(THRE_ARM_ON_EN)) u_thre (
      .clk(clk), .rst_n(rst_n), .empty_i(thr_empty_i), .en_i(src_en_i[EN_THRE]),
      .clr_i(thre_clr), .flag_o(thre_q));

   always_comb begin
      pend.line = line_q  & src_en_i[EN_LINE];
      pend.rxd  = rx_src  & src_en_i[EN_RXD];
      pend.tmo  = tmo_src & src_en_i[EN_RXD];
      pend.thre = thre_q  & src_en_i[EN_THRE];
      pend.mdm  = mdm_q   & src_en_i[EN_MDM];
   end

   uirq_prio u_prio (.pend_i(pend), .iid_o(code), .pend_n_o(int_pend_n_o));

   assign iid_o = code;
   assign irq_o = out_en_i & ~int_pend_n_o;
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fifo_mode_i,
   input logic [3:0] src_en_i,
   input logic       out_en_i,
   input logic       line_err_i,
   input logic       msr_evt_i,
   input logic       rd_lsr_i,
   input logic       rd_msr_i,
   input logic [2:0] iid_o,
   input logic       int_pend_n_o,
   input logic       irq_o
);
   p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int_pend_n_o |-> (iid_o == 3'b000));

   p_line_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_err_i && src_en_i[2]) |=> (!src_en_i[2] || (!int_pend_n_o && iid_o == 3'b011)));

   p_lsr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lsr_i && !line_err_i) |=> !(!int_pend_n_o && iid_o == 3'b011));

   p_msr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_msr_i && !msr_evt_i) |=> !(!int_pend_n_o && iid_o == 3'b000));

   p_irq_needs_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !int_pend_n_o);

   p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en_i |-> !irq_o);

   p_iid2_char_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_mode_i |-> !iid_o[2]);
endmodule

bind uart_irq_ident uirq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode_i), .src_en_i(src_en_i),
   .out_en_i(out_en_i), .line_err_i(line_err_i), .msr_evt_i(msr_evt_i),
   .rd_lsr_i(rd_lsr_i), .rd_msr_i(rd_msr_i), .iid_o(iid_o),
   .int_pend_n_o(int_pend_n_o), .irq_o(irq_o));

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
   logic clk = 1'b0;
   logic rst_n;
   logic fifo_mode_i, out_en_i;
   logic [3:0] src_en_i;
   logic line_err_i, rx_evt_i, rx_trig_i, rx_tmo_i, thr_empty_i, msr_evt_i;
   logic rd_iir_i, rd_lsr_i, rd_rbr_i, rd_msr_i, wr_thr_i;
   logic [2:0] iid_o;
   logic int_pend_n_o, irq_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_irq_ident dut (
      .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode_i), .src_en_i(src_en_i),
      .out_en_i(out_en_i), .line_err_i(line_err_i), .rx_evt_i(rx_evt_i),
      .rx_trig_i(rx_trig_i), .rx_tmo_i(rx_tmo_i), .thr_empty_i(thr_empty_i),
      .msr_evt_i(msr_evt_i), .rd_iir_i(rd_iir_i), .rd_lsr_i(rd_lsr_i),
      .rd_rbr_i(rd_rbr_i), .rd_msr_i(rd_msr_i), .wr_thr_i(wr_thr_i),
      .iid_o(iid_o), .int_pend_n_o(int_pend_n_o), .irq_o(irq_o));

   // Expected {iid, pend_n} from requirements R2..R10, R12.
   function automatic logic [3:0] expect_id(input logic [4:0] m, input logic [3:0] en,
                                             input logic fifo);
      logic line_p, rx_p, tmo_p, thre_p, mdm_p;
      line_p = m[0] & en[2];
      rx_p   = m[1] & en[0];
      tmo_p  = m[2] & fifo & en[0];
      thre_p = m[3] & en[1];
      mdm_p  = m[4] & en[3];
      if (line_p)      return 4'b0110;
      else if (rx_p)   return 4'b0100;
      else if (tmo_p)  return 4'b1100;
      else if (thre_p) return 4'b0010;
      else if (mdm_p)  return 4'b0000;
      else             return 4'b0001;
   endfunction

   task automatic check_out(input logic [3:0] exp, input logic oe, input string req);
      n_vec++;
      if ({iid_o, int_pend_n_o} !== exp || irq_o !== (oe & ~exp[0])) begin
         n_bad++;
         $display("FAIL %s: got iid=%b pend_n=%b irq=%b, expected iid=%b pend_n=%b irq=%b",
                  req, iid_o, int_pend_n_o, irq_o, exp[3:1], exp[0], oe & ~exp[0]);
      end
   endtask

   task automatic quiet_pulses();
      line_err_i = 0; rx_evt_i = 0; msr_evt_i = 0;
      rd_iir_i = 0; rd_lsr_i = 0; rd_rbr_i = 0; rd_msr_i = 0; wr_thr_i = 0;
   endtask

   task automatic do_reset(input logic empty_lvl);
      quiet_pulses();
      fifo_mode_i = 0; out_en_i = 1; src_en_i = 4'h0;
      rx_trig_i = 0; rx_tmo_i = 0; thr_empty_i = empty_lvl;
      rst_n = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0);
      check_out(4'b0001, 1'b1, "R1 reset state");

      // Sweep: all source mixes x enables x modes; identification read each time.
      for (int f = 0; f < 2; f++) begin
         for (int en = 0; en < 16; en++) begin
            for (int m = 0; m < 32; m++) begin
               logic [4:0] mk;
               logic [3:0] e1;
               logic oe;
               mk = m[4:0];
               oe = m[0] ^ en[0] ^ f[0] ^ 1'b1;
               do_reset(1'b0);
               step();                     // quiet cycle so empty level is seen low
               fifo_mode_i = f[0];
               src_en_i    = en[3:0];
               out_en_i    = oe;
               line_err_i  = mk[0];
               rx_evt_i    = f[0] ? 1'b0 : mk[1];
               rx_trig_i   = f[0] ? mk[1] : 1'b0;
               rx_tmo_i    = mk[2];
               thr_empty_i = mk[3];
               msr_evt_i   = mk[4];
               step();
               e1 = expect_id(mk, en[3:0], f[0]);
               // R2 R3 R4 R5 R6 R9 R10 R11 R12: priority and gating across the mix
               check_out(e1, oe, "R2/R5/R6/R9/R10/R11/R12 sweep");
               quiet_pulses();
               rd_iir_i = 1;
               step();
               rd_iir_i = 0;
               // R6 clear on read when shown, R7 survival otherwise
               if (e1 == 4'b0010) mk[3] = 1'b0;
               if (!f[0]) mk[2] = 1'b0;
               check_out(expect_id(mk, en[3:0], f[0]), oe, "R6/R7 identification read");
            end
         end
      end

      // R6: write to holding register clears, new edge re-arms
      do_reset(1'b0);
      src_en_i = 4'b0010; step();
      thr_empty_i = 1; step();
      check_out(4'b0010, 1'b1, "R6 armed by empty edge");
      thr_empty_i = 0; wr_thr_i = 1; step();
      wr_thr_i = 0;
      check_out(4'b0001, 1'b1, "R6 cleared by holding write");
      thr_empty_i = 1; step();
      check_out(4'b0010, 1'b1, "R6 re-armed by next empty edge");

      // R8: enable edge while already empty
      do_reset(1'b1);
      step();
      check_out(4'b0001, 1'b1, "R8 no arm while disabled");
      src_en_i = 4'b0010; step();
      check_out(4'b0010, 1'b1, "R8 armed by enable edge");
      rd_iir_i = 1; step(); rd_iir_i = 0;
      check_out(4'b0001, 1'b1, "R6 cleared by identification read");
      src_en_i = 4'b0000; step();
      src_en_i = 4'b0010; step();
      check_out(4'b0010, 1'b1, "R8 re-armed by second enable edge");

      // R7: THRE hidden behind line error survives a read
      src_en_i = 4'b0110; line_err_i = 1; step(); line_err_i = 0;
      check_out(4'b0110, 1'b1, "R2 line error on top of R6");
      rd_iir_i = 1; step(); rd_iir_i = 0;
      check_out(4'b0110, 1'b1, "R7 read while line error shown");
      rd_lsr_i = 1; step(); rd_lsr_i = 0;
      check_out(4'b0010, 1'b1, "R7 THRE still armed after line clear");

      // R3: wrong read does not clear, receive-buffer read does
      do_reset(1'b0);
      src_en_i = 4'b1111; rx_evt_i = 1; step(); rx_evt_i = 0;
      check_out(4'b0100, 1'b1, "R3 received character");
      rd_lsr_i = 1; rd_msr_i = 1; step(); rd_lsr_i = 0; rd_msr_i = 0;
      check_out(4'b0100, 1'b1, "R3 other reads ignored");
      rd_rbr_i = 1; step(); rd_rbr_i = 0;
      check_out(4'b0001, 1'b1, "R3 cleared by buffer read");
      rx_tmo_i = 1; step();
      check_out(4'b0001, 1'b1, "R12 timeout ignored in character mode");
      rx_tmo_i = 0;

      // R9: modem change and its clear
      msr_evt_i = 1; step(); msr_evt_i = 0;
      check_out(4'b0000, 1'b1, "R9 modem change");
      rd_msr_i = 1; step(); rd_msr_i = 0;
      check_out(4'b0001, 1'b1, "R9 cleared by modem status read");

      // R4/R5: FIFO trigger level follows input, timeout behind it
      fifo_mode_i = 1; rx_trig_i = 1; rx_tmo_i = 1; step();
      check_out(4'b0100, 1'b1, "R5 data ahead of timeout");
      rx_trig_i = 0; step();
      check_out(4'b1100, 1'b1, "R4 trigger fell, R5 timeout shown");
      rx_tmo_i = 0; step();
      check_out(4'b0001, 1'b1, "R4 nothing left");
      out_en_i = 0; rx_trig_i = 1; step();
      check_out(4'b0100, 1'b0, "R11 request gated off");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule